// File: doc/BRIEF.md
# Four-Times Oversampled Serial Data Recovery

This block pulls serial data out of a line that is sampled four times per bit. It runs on a core clock at half the bit rate. Each clock it receives eight line samples 45 degrees of that clock apart, which covers two bit periods. They arrive as two groups of four. One group is taken straight from the line at 0, 90, 180 and 270 degrees. The other is taken from a copy of the line delayed by 45 degrees, so it holds 45, 135, 225 and 315 degrees.

The block puts the samples in time order and looks for transitions between neighbouring samples. It keeps a sampling slot that sits half a bit away from the transitions. It moves that slot only when the same drift shows up on two clocks in a row. Normally it emits two bits per clock. When the slot crosses the edge of a bit period, it emits three bits or one bit instead. This lets the transmitter and receiver clocks differ slightly. A lock flag shows when the slot has been still for a set number of clocks.

The line decoder that follows takes the bit bus together with the valid count. Bits are packed oldest first from bit 0.

Top module: `os_data_recovery`

## Requirements
- R1: Samples are put in time order before any other processing. Time slot 2i holds bit i of the undelayed group `samp_even_i`, and slot 2i+1 holds bit i of the delayed group `samp_odd_i` (i = 0..3). Slot 0 is the oldest sample and slot 7 the newest.
- R2: Transition k (k = 0..7) is the XOR of slot k with slot k-1. For k = 0 the previous sample is slot 7 of the previous clock, so a transition across the clock boundary also counts. Transition class j (j = 0..3) is set when transition j or transition j+4 is set.
- R3: The sampling slot m (0..3, starting at 0) gets a verdict on each clock. The verdict is "late" when class (m+3) mod 4 is set and class (m+1) mod 4 is clear. It is "early" when class (m+1) mod 4 is set and class (m+3) mod 4 is clear. Otherwise it is "none". m steps by +1 (late) or -1 (early), modulo 4, only when the same verdict was also reached on the previous clock. A step clears the remembered verdict. m moves at most one step per clock.
- R4: The outputs are registered. A window applied before a rising edge shows its result after that edge. Without a wrap, `rx_count_o` = 2, bit 0 = slot m, bit 1 = slot m+4 and bit 2 = 0, where m is the slot after that clock's update.
- R5: When m steps from 0 to 3, that clock emits 3 bits. Bit 0 is the previous clock's slot 7, bit 1 is slot 3 and bit 2 is slot 7.
- R6: When m steps from 3 to 0, that clock emits 1 bit. Bit 0 is slot 4 and bits 2:1 are 0.
- R7: `locked_o` rises on the edge that completes 16 consecutive clocks without a step. It falls on the edge of the clock in which a step happens, and then the 16-clock count starts again.
- R8: While `rst_ni` is low, the outputs are driven to zero. m resets to 0, the remembered verdict to none and the stored boundary sample to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock at half the bit rate |
| rst_ni | input | 1 | Active-low synchronous reset |
| samp_even_i | input | 4 | Undelayed samples at 0/90/180/270 degrees, bit 0 earliest |
| samp_odd_i | input | 4 | 45-degree delayed samples at 45/135/225/315 degrees, bit 0 earliest |
| rx_bits_o | output | 3 | Recovered bits, oldest in bit 0 |
| rx_count_o | output | 2 | Number of valid bits in rx_bits_o (1, 2 or 3; 0 in reset) |
| locked_o | output | 1 | Sampling slot has been stable for 16 clocks |

## Verification
The hardest cases to reach are the wraps of the sampling slot. A three-bit or one-bit clock happens only after two agreeing verdicts in a row while the slot sits at the end of its range. Directed windows with transitions placed at chosen classes walk the slot step by step into both wraps. A single off-centre window between centred ones shows that one verdict alone moves nothing. Randomised streams then come from a sample-phase accumulator running slightly fast or slightly slow, with added jitter. This drives the tracker through wraps repeatedly in both directions.

// File: rtl/ovr_pkg.sv
package ovr_pkg;
    localparam int SAMP_PER_UI  = 4;
    localparam int SAMP_PER_CLK = 2 * SAMP_PER_UI;
    localparam int PH_W         = $clog2(SAMP_PER_UI);
    localparam int OUT_W        = 3;
    localparam int CNT_W        = 2;

    typedef logic [PH_W-1:0]         phase_t;
    typedef logic [SAMP_PER_CLK-1:0] window_t;
    typedef logic [SAMP_PER_UI-1:0]  cls_t;

    typedef enum logic [1:0] {
        VERD_NONE  = 2'd0,
        VERD_LATE  = 2'd1,
        VERD_EARLY = 2'd2
    } verdict_e;
endpackage

// File: rtl/ovr_edge_classes.sv
module ovr_edge_classes
    import ovr_pkg::*;
(
    input  logic    prev_last_i,
    input  window_t win_i,
    output cls_t    cls_o
);
    logic [SAMP_PER_CLK-1:0] trans;

    assign trans[0] = prev_last_i ^ win_i[0];

    generate
        for (genvar k = 1; k < SAMP_PER_CLK; k++) begin : g_trans
            assign trans[k] = win_i[k-1] ^ win_i[k];
        end
        for (genvar j = 0; j < SAMP_PER_UI; j++) begin : g_cls
            assign cls_o[j] = trans[j] | trans[j+SAMP_PER_UI];
        end
    endgenerate
endmodule

// File: rtl/ovr_phase_track.sv
module ovr_phase_track
    import ovr_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  cls_t   cls_i,
    output phase_t phase_o,
    output logic   step_o,
    output logic   wrap_fwd_o,
    output logic   wrap_back_o
);
    localparam phase_t LATE_OFS  = phase_t'(SAMP_PER_UI/2 - 1);
    localparam phase_t EARLY_OFS = phase_t'(SAMP_PER_UI/2 + 1);
    localparam phase_t PH_MAX    = phase_t'(SAMP_PER_UI - 1);

    typedef struct packed {
        phase_t   phase;
        verdict_e hist;
    } trk_t;

    trk_t state_d, state_q;
    phase_t   phase_q, up_ph, dn_ph, late_idx, early_idx;
    verdict_e verdict;
    logic     seen_late, seen_early, go_late, go_early;

    assign phase_q = state_q.phase;

    always_comb begin
        up_ph      = phase_t'(phase_q + 1'b1);
        dn_ph      = phase_t'(phase_q - 1'b1);
        late_idx   = phase_t'(phase_q - LATE_OFS);
        early_idx  = phase_t'(phase_q - EARLY_OFS);
        seen_late  = cls_i[late_idx];
        seen_early = cls_i[early_idx];

        if (seen_late && !seen_early) begin
            verdict = VERD_LATE;
        end else if (seen_early && !seen_late) begin
            verdict = VERD_EARLY;
        end else begin
            verdict = VERD_NONE;
        end

        go_late  = (verdict == VERD_LATE)  && (state_q.hist == VERD_LATE);
        go_early = (verdict == VERD_EARLY) && (state_q.hist == VERD_EARLY);

        state_d = state_q;
        if (go_late) begin
            state_d.phase = up_ph;
            state_d.hist  = VERD_NONE;
        end else if (go_early) begin
            state_d.phase = dn_ph;
            state_d.hist  = VERD_NONE;
        end else begin
            state_d.hist  = verdict;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '{phase: '0, hist: VERD_NONE};
        end else begin
            state_q <= state_d;
        end
    end

    assign phase_o     = state_d.phase;
    assign step_o      = go_late | go_early;
    assign wrap_fwd_o  = go_late  && (phase_q == PH_MAX);
    assign wrap_back_o = go_early && (phase_q == '0);

    assert_single_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q == $past(phase_q)) ||
        (phase_q == phase_t'($past(phase_q) + 1'b1)) ||
        (phase_q == phase_t'($past(phase_q) - 1'b1)));

    assert_step_needs_history_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q != $past(phase_q)) |-> ($past(state_q.hist) != VERD_NONE));
endmodule

// File: rtl/ovr_bit_pick.sv
module ovr_bit_pick
    import ovr_pkg::*;
(
    input  window_t          win_i,
    input  logic             prev_last_i,
    input  phase_t           phase_i,
    input  logic             wrap_fwd_i,
    input  logic             wrap_back_i,
    output logic [OUT_W-1:0] bits_o,
    output logic [CNT_W-1:0] cnt_o
);
    always_comb begin
        if (wrap_back_i) begin
            bits_o = {win_i[SAMP_PER_CLK-1], win_i[SAMP_PER_UI-1], prev_last_i};
            cnt_o  = CNT_W'(3);
        end else if (wrap_fwd_i) begin
            bits_o = {2'b00, win_i[SAMP_PER_UI]};
            cnt_o  = CNT_W'(1);
        end else begin
            bits_o = {1'b0, win_i[{1'b1, phase_i}], win_i[{1'b0, phase_i}]};
            cnt_o  = CNT_W'(2);
        end
    end
endmodule

// File: rtl/ovr_lock_mon.sv
module ovr_lock_mon #(
    parameter int LOCK_CLKS = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_i,
    output logic locked_o
);
    localparam int CW = $clog2(LOCK_CLKS + 1);
    localparam logic [CW-1:0] QUIET_MAX = CW'(LOCK_CLKS);

    typedef struct packed {
        logic [CW-1:0] quiet;
        logic          locked;
    } lock_t;

    lock_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (step_i) begin
            lk_d.quiet = '0;
        end else if (lk_q.quiet != QUIET_MAX) begin
            lk_d.quiet = lk_q.quiet + CW'(1);
        end
        lk_d.locked = (lk_d.quiet == QUIET_MAX);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lk_q <= '{quiet: '0, locked: 1'b0};
        end else begin
            lk_q <= lk_d;
        end
    end

    assign locked_o = lk_q.locked;

    assert_lock_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |=> !locked_o);

    assert_lock_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |-> !$past(step_i));
endmodule

// File: rtl/os_data_recovery.sv
module os_data_recovery
    import ovr_pkg::*;
#(
    parameter int LOCK_CLKS = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [SAMP_PER_UI-1:0] samp_even_i,
    input  logic [SAMP_PER_UI-1:0] samp_odd_i,
    output logic [OUT_W-1:0]       rx_bits_o,
    output logic [CNT_W-1:0]       rx_count_o,
    output logic                   locked_o
);
    typedef struct packed {
        logic             prev_last;
        logic [OUT_W-1:0] bits;
        logic [CNT_W-1:0] cnt;
    } out_t;

    out_t    r_d, r_q;
    window_t win;
    cls_t    cls;
    phase_t  phase_new;
    logic    step, wrap_fwd, wrap_back;
    logic [OUT_W-1:0] pick_bits;
    logic [CNT_W-1:0] pick_cnt;

    generate
        for (genvar i = 0; i < SAMP_PER_UI; i++) begin : g_interleave
            assign win[2*i]   = samp_even_i[i];
            assign win[2*i+1] = samp_odd_i[i];
        end
    endgenerate

    ovr_edge_classes u_edges (
        .prev_last_i (r_q.prev_last),
        .win_i       (win),
        .cls_o       (cls)
    );

    ovr_phase_track u_track (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cls_i       (cls),
        .phase_o     (phase_new),
        .step_o      (step),
        .wrap_fwd_o  (wrap_fwd),
        .wrap_back_o (wrap_back)
    );

    ovr_bit_pick u_pick (
        .win_i       (win),
        .prev_last_i (r_q.prev_last),
        .phase_i     (phase_new),
        .wrap_fwd_i  (wrap_fwd),
        .wrap_back_i (wrap_back),
        .bits_o      (pick_bits),
        .cnt_o       (pick_cnt)
    );

    ovr_lock_mon #(.LOCK_CLKS(LOCK_CLKS)) u_lock (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .step_i   (step),
        .locked_o (locked_o)
    );

    always_comb begin
        r_d.prev_last = win[SAMP_PER_CLK-1];
        r_d.bits      = pick_bits;
        r_d.cnt       = pick_cnt;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_bits_o  = r_q.bits;
    assign rx_count_o = r_q.cnt;

    assert_count_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (rx_count_o != '0));

    assert_three_on_back_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_back |=> (rx_count_o == CNT_W'(3)));

    assert_one_on_fwd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_fwd |=> (rx_count_o == CNT_W'(1)));
endmodule

// File: tb/os_data_recovery_tb_top.sv
module os_data_recovery_tb_top;
    localparam int LOCK = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] samp_even = '0;
    logic [3:0] samp_odd = '0;
    logic [2:0] rx_bits;
    logic [1:0] rx_count;
    logic       locked;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string sec = "";

    int   m_ph, m_hist, m_cnt;
    logic m_prev;
    logic [2:0] e_bits;
    logic [1:0] e_cnt;
    logic e_lock;
    logic lastb;
    int n3 = 0, n1 = 0;
    int ph = 0, cur_idx = 0;
    logic cur_bit = 1'b0;

    always #5 clk = ~clk;

    os_data_recovery #(.LOCK_CLKS(LOCK)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .samp_even_i (samp_even),
        .samp_odd_i  (samp_odd),
        .rx_bits_o   (rx_bits),
        .rx_count_o  (rx_count),
        .locked_o    (locked)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic mreset();
        m_ph = 0; m_hist = 0; m_cnt = 0; m_prev = 1'b0; lastb = 1'b0;
    endtask

    task automatic model(input logic [3:0] ev, input logic [3:0] od);
        logic [7:0] w, t;
        logic [3:0] c;
        logic late, early, st_l, st_e;
        int v, nm;
        for (int i = 0; i < 4; i++) begin
            w[2*i] = ev[i];
            w[2*i+1] = od[i];
        end
        t[0] = m_prev ^ w[0];
        for (int i = 1; i < 8; i++) t[i] = w[i-1] ^ w[i];
        for (int j = 0; j < 4; j++) c[j] = t[j] | t[j+4];
        late  = c[(m_ph + 3) % 4];
        early = c[(m_ph + 1) % 4];
        v = (late && !early) ? 1 : ((early && !late) ? 2 : 0);
        st_l = (v == 1) && (m_hist == 1);
        st_e = (v == 2) && (m_hist == 2);
        nm = st_l ? (m_ph + 1) % 4 : (st_e ? (m_ph + 3) % 4 : m_ph);
        if (st_e && m_ph == 0) begin
            e_bits = {w[7], w[3], m_prev}; e_cnt = 2'd3;
        end else if (st_l && m_ph == 3) begin
            e_bits = {2'b00, w[4]}; e_cnt = 2'd1;
        end else begin
            e_bits = {1'b0, w[nm+4], w[nm]}; e_cnt = 2'd2;
        end
        m_hist = (st_l || st_e) ? 0 : v;
        m_ph = nm;
        m_prev = w[7];
        if (st_l || st_e) m_cnt = 0;
        else if (m_cnt < LOCK) m_cnt++;
        e_lock = (m_cnt == LOCK);
    endtask

    task automatic drive(input logic [3:0] ev, input logic [3:0] od);
        string tag;
        model(ev, od);
        samp_even = ev;
        samp_odd = od;
        @(negedge clk);
        if (sec != "") tag = sec;
        else tag = (e_cnt == 2'd3) ? "R5" : ((e_cnt == 2'd1) ? "R6" : "R4");
        chk(tag, "bits", int'(rx_bits), int'(e_bits));
        chk(tag, "count", int'(rx_count), int'(e_cnt));
        chk("R7", "lock", int'(locked), int'(e_lock));
        if (rx_count == 2'd3) n3++;
        if (rx_count == 2'd1) n1++;
    endtask

    function automatic logic [7:0] mkwin(int c, logic p, logic a, logic b);
        logic [7:0] w;
        for (int i = 0; i < 8; i++) w[i] = (i < c) ? p : ((i < c + 4) ? a : b);
        return w;
    endfunction

    task automatic dwin(input int c);
        logic [7:0] w;
        logic [3:0] ev, od;
        logic a, b;
        a = ~lastb;
        b = ~a;
        w = mkwin(c, lastb, a, b);
        lastb = b;
        for (int i = 0; i < 4; i++) begin
            ev[i] = w[2*i];
            od[i] = w[2*i+1];
        end
        drive(ev, od);
    endtask

    task automatic stream(input int n, input int stepv, input int jit);
        logic [7:0] w;
        logic [3:0] ev, od;
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 8; i++) begin
                ph += stepv + (int'($urandom_range(0, 2 * jit)) - jit);
                while (ph / 1000 > cur_idx) begin
                    cur_idx++;
                    cur_bit = 1'($urandom_range(0, 1));
                end
                w[i] = cur_bit;
            end
            for (int i = 0; i < 4; i++) begin
                ev[i] = w[2*i];
                od[i] = w[2*i+1];
            end
            drive(ev, od);
        end
    endtask

    task automatic do_reset();
        samp_even = '0;
        samp_odd = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "reset bits", int'(rx_bits), 0);
        chk("R8", "reset count", int'(rx_count), 0);
        chk("R8", "reset lock", int'(locked), 0);
        rst_n = 1'b1;
        mreset();
    endtask

    initial begin
        #(10 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog: actual=timeout expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        mreset();
        @(negedge clk);
        do_reset();

        // R7: centred transitions, lock after 16 quiet clocks
        sec = "R7";
        for (int k = 0; k < 20; k++) dwin(2);
        chk("R7", "locked after quiet run", int'(locked), 1);

        // R3: a single late verdict does not move the slot
        sec = "R3";
        dwin(3);
        for (int k = 0; k < 3; k++) dwin(2);
        chk("R3", "lock kept after lone verdict", int'(locked), 1);
        dwin(3);
        dwin(3);
        chk("R3", "lock dropped after two late verdicts", int'(locked), 0);

        sec = "R4";
        for (int k = 0; k < 3; k++) dwin(3);

        // R2: transitions across the clock boundary give a late verdict at slot 1
        sec = "R2";
        dwin(0);
        dwin(0);

        // R5: walk the slot earlier down to a 0 -> 3 wrap
        sec = "R5";
        dwin(3); dwin(3);
        dwin(2); dwin(2);
        dwin(1); dwin(1);
        chk("R5", "three-bit count at wrap", int'(rx_count), 3);

        // R6: slot 3 -> 0 wrap
        sec = "R6";
        dwin(2); dwin(2);
        chk("R6", "one-bit count at wrap", int'(rx_count), 1);

        // R1: raw lane patterns exercise the interleave order
        sec = "R1";
        drive(4'b0011, 4'b0110);
        drive(4'b1010, 4'b0101);
        for (int k = 0; k < 30; k++) drive(4'($urandom()), 4'($urandom()));

        // R8: mid-run reset
        do_reset();

        sec = "";
        stream(300, 250, 20);
        n3 = 0; n1 = 0;
        stream(400, 256, 10);
        chk("R5", "three-bit clocks seen with fast data", int'(n3 > 0), 1);
        stream(400, 244, 10);
        chk("R6", "one-bit clocks seen with slow data", int'(n1 > 0), 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule